// File: doc/BRIEF.md
# Direct-Sequence Chip Spreader

The block turns a repeating parallel data word into a direct-sequence spread chip stream. A four-stage linear feedback shift register produces a maximal-length pseudo-noise chip sequence of period 15. The register uses an XNOR feedback gate. A serializer captures the parallel word and presents one data bit for each complete PN period. An equality gate then combines each data bit with the running chip. On 0/1 logic levels this gives the same result as multiplying the ±1 levels.

All state runs on a single clock. A chip-enable strobe sets the chip rate, so there are no derived or gated clocks. A period marker shows which chip opens each PN period. The raw PN chip and the current data bit are also brought out, so a receiver model or a later stage can line itself up with them. Carrier modulation and level conversion belong to later stages.

Top module: `dsss_spreader`

## Requirements
- R1: While `rst` is sampled high at a clock edge, the block enters its reset state. The shift register is all zeros and the serializer is empty with its bit counter at terminal count. After that edge, `pn_o`=0, `period_o`=1, `data_o`=0 and `spread_o`=1.
- R2: Each edge with `chip_en` high advances the PN register one chip. Starting from reset, `pn_o` over chips 0 to 14 is 0,0,0,0,1,1,1,0,1,1,0,0,1,0,1, and then the sequence repeats with period 15.
- R3: Every 15-chip period contains exactly seven chips with `pn_o`=1 and eight with `pn_o`=0.
- R4: The PN register never holds the all-ones lockup state, so `pn_o` is never 1 on four consecutive chips.
- R5: `period_o` is high on exactly one chip per period: chip 0, the chip where the register holds all zeros.
- R6: `data_o` changes only at the edge that raises `period_o`. Each data bit therefore lasts exactly 15 chips.
- R7: The word is sent MSB first. At the first period start after reset, `word_in` is captured and its bit 7 is shown. Bits 6 to 0 follow, one per period. At the period start after bit 0, a new `word_in` is captured. A change of `word_in` between captures has no effect on the word being sent.
- R8: `spread_o` is 1 when `data_o` equals `pn_o` and 0 otherwise, on every chip.
- R9: At an edge where `chip_en` is low, `pn_o`, `period_o`, `data_o` and `spread_o` keep their values.
- R10: A reset asserted in the middle of a word returns the block to the R1 state. The chip sequence and word capture then restart from chip 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Single clock for all state |
| rst | input | 1 | Synchronous reset, active high |
| chip_en | input | 1 | Chip-rate strobe; one chip per high cycle |
| word_in | input | 8 | Parallel data word, captured at word boundaries |
| spread_o | output | 1 | Spread chip: XNOR of data bit and PN chip |
| pn_o | output | 1 | Raw PN chip |
| data_o | output | 1 | Data bit currently being spread |
| period_o | output | 1 | High on the first chip of each PN period |

## Verification
The assertions check four things on every cycle:
- the lockup state never appears in the PN register;
- outputs hold still when the strobe is low;
- the data bit moves only when a period opens;
- the period marker never lasts longer than one chip.

Some behaviours can only be shown by the bench's scenarios, because they need a reference over many chips:
- the exact chip order and the 7/8 balance;
- the MSB-first bit order and when the word is captured;
- immunity to word changes in the middle of a word;
- the restart after a reset in the middle of a word.

// File: rtl/dsss_pkg.sv
package dsss_pkg;
    // PN register geometry; taps at the two top stages give a 15-chip period
    parameter int unsigned PN_W     = 4;
    parameter int unsigned TAP_HI   = PN_W - 1;
    parameter int unsigned TAP_LO   = PN_W - 2;
    parameter int unsigned WORD_W   = 8;
    localparam int unsigned CNT_W   = $clog2(WORD_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WORD_W - 1);

    typedef logic [PN_W-1:0] pn_state_t;

    typedef struct packed {
        pn_state_t sr;
    } lfsr_regs_t;

    typedef struct packed {
        logic [WORD_W-1:0] shreg;
        logic [CNT_W-1:0]  cnt;
    } ser_regs_t;
endpackage

// File: rtl/chip_lfsr.sv
module chip_lfsr
    import dsss_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      step_i,
    output logic      chip_o,
    output logic      start_o,
    output logic      wrap_o,
    output pn_state_t state_o
);
    lfsr_regs_t r_d, r_q;
    pn_state_t  shifted;

    // shift chain, feedback enters stage 0
    assign shifted[0] = ~(r_q.sr[TAP_HI] ^ r_q.sr[TAP_LO]);
    genvar gi;
    generate
        for (gi = 1; gi < int'(PN_W); gi++) begin : g_chain
            assign shifted[gi] = r_q.sr[gi-1];
        end
    endgenerate

    always_comb begin
        r_d    = r_q;
        wrap_o = 1'b0;
        if (rst) begin
            r_d.sr = '0;
        end else if (step_i) begin
            r_d.sr = shifted;
            wrap_o = (shifted == '0);
        end
    end

    always_ff @(posedge clk) begin
        r_q <= r_d;
    end

    assign chip_o  = r_q.sr[PN_W-1];
    assign start_o = (r_q.sr == '0);
    assign state_o = r_q.sr;
endmodule

// File: rtl/word_serializer.sv
module word_serializer
    import dsss_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              adv_i,
    input  logic [WORD_W-1:0] word_i,
    output logic              bit_o
);
    ser_regs_t r_d, r_q;
    logic      term;

    // terminal count doubles as the parallel-load request
    assign term = (r_q.cnt == CNT_LAST);

    always_comb begin
        r_d = r_q;
        if (rst) begin
            r_d.shreg = '0;
            r_d.cnt   = CNT_LAST;
        end else if (adv_i) begin
            if (term) begin
                r_d.shreg = word_i;
                r_d.cnt   = '0;
            end else begin
                r_d.shreg = {r_q.shreg[WORD_W-2:0], 1'b0};
                r_d.cnt   = r_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        r_q <= r_d;
    end

    assign bit_o = r_q.shreg[WORD_W-1];
endmodule

// File: rtl/chip_spreader.sv
module chip_spreader (
    input  logic data_i,
    input  logic chip_i,
    output logic spread_o
);
    // equality on 0/1 levels matches the product of the +/-1 levels
    assign spread_o = ~(data_i ^ chip_i);
endmodule

// File: rtl/dsss_spreader.sv
module dsss_spreader
    import dsss_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              chip_en,
    input  logic [WORD_W-1:0] word_in,
    output logic              spread_o,
    output logic              pn_o,
    output logic              data_o,
    output logic              period_o
);
    logic      wrap;
    pn_state_t lfsr_state;

    chip_lfsr u_lfsr (
        .clk     (clk),
        .rst     (rst),
        .step_i  (chip_en),
        .chip_o  (pn_o),
        .start_o (period_o),
        .wrap_o  (wrap),
        .state_o (lfsr_state)
    );

    word_serializer u_ser (
        .clk    (clk),
        .rst    (rst),
        .adv_i  (wrap),
        .word_i (word_in),
        .bit_o  (data_o)
    );

    chip_spreader u_spread (
        .data_i   (data_o),
        .chip_i   (pn_o),
        .spread_o (spread_o)
    );
endmodule

// File: rtl/dsss_spreader_chk.sv
module dsss_spreader_chk
    import dsss_pkg::*;
(
    input logic      clk,
    input logic      rst,
    input logic      chip_en,
    input logic      pn_o,
    input logic      data_o,
    input logic      period_o,
    input pn_state_t lfsr_state
);
    AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
        (!rst && $past(rst)) |-> (period_o && !pn_o && !data_o)); // R1

    AST_NO_LOCKUP: assert property (@(posedge clk) disable iff (rst)
        lfsr_state != '1); // R4

    AST_MARKER_ONE_CHIP: assert property (@(posedge clk) disable iff (rst)
        (period_o && chip_en) |=> !period_o); // R5

    AST_DATA_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
        (data_o != $past(data_o)) |-> period_o); // R6

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !chip_en |=> $stable({pn_o, data_o, period_o})); // R9
endmodule

bind dsss_spreader dsss_spreader_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .chip_en    (chip_en),
    .pn_o       (pn_o),
    .data_o     (data_o),
    .period_o   (period_o),
    .lfsr_state (lfsr_state)
);

// File: tb/tb_dsss_spreader.sv
`timescale 1ns/1ps
module tb_dsss_spreader;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic       rst, chip_en;
    logic [7:0] word_in;
    logic       spread_o, pn_o, data_o, period_o;

    dsss_spreader dut (
        .clk(clk), .rst(rst), .chip_en(chip_en), .word_in(word_in),
        .spread_o(spread_o), .pn_o(pn_o), .data_o(data_o), .period_o(period_o)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    // R2 chip order from reset, index 0 first
    logic [0:14] PN_SEQ = 15'b000011101100101;

    // reference model built from R1, R2, R7
    int         m_c;
    logic [7:0] m_sh;
    int         m_cnt;

    task automatic model_reset();
        m_c = 0; m_sh = 8'h00; m_cnt = 7;
    endtask

    task automatic model_chip();
        m_c = (m_c + 1) % 15;
        if (m_c == 0) begin
            if (m_cnt == 7) begin m_sh = word_in; m_cnt = 0; end
            else begin m_sh = {m_sh[6:0], 1'b0}; m_cnt++; end
        end
    endtask

    task automatic tick(input logic en);
        chip_en = en;
        @(posedge clk);
        #1;
        if (rst) model_reset();
        else if (en) model_chip();
    endtask

    task automatic chk(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        logic ep, ed;
        ep = PN_SEQ[m_c];
        ed = m_sh[7];
        chk({tag, " pn_o"}, pn_o, ep);
        chk({tag, " period_o"}, period_o, (m_c == 0));
        chk({tag, " data_o"}, data_o, ed);
        chk({tag, " spread_o R8"}, spread_o, ~(ep ^ ed));
    endtask

    task automatic t_reset();
        rst = 1'b1; word_in = 8'hA5;
        for (int i = 0; i < 3; i++) tick(1'b1);
        chk("R1 pn_o", pn_o, 1'b0);
        chk("R1 period_o", period_o, 1'b1);
        chk("R1 data_o", data_o, 1'b0);
        chk("R1 spread_o", spread_o, 1'b1);
        rst = 1'b0;
    endtask

    task automatic t_pn_seq();
        for (int i = 0; i < 30; i++) begin
            tick(1'b1);
            check_all("R2 R5");
        end
    endtask

    task automatic t_balance();
        int ones, run, maxrun;
        while (period_o !== 1'b1) tick(1'b1);
        ones = 0;
        for (int i = 0; i < 15; i++) begin
            ones += int'(pn_o);
            tick(1'b1);
        end
        chk("R3 seven ones per period", (ones == 7), 1'b1);
        if (ones != 7) $display("FAIL R3 actual=%0d expected=7", ones);
        run = 0; maxrun = 0;
        for (int i = 0; i < 45; i++) begin
            run = pn_o ? run + 1 : 0;
            if (run > maxrun) maxrun = run;
            tick(1'b1);
        end
        chk("R4 ones run at most three", (maxrun <= 3), 1'b1);
    endtask

    task automatic t_word();
        int  chips;
        logic [7:0] got;
        // align to a fresh word capture, then change word mid-word
        word_in = 8'hA5;
        chips = 0;
        for (int i = 0; i < 15 * 8 * 2; i++) begin
            tick(1'b1);
            check_all("R6 R7");
            if (i == 200) word_in = 8'h3C;
        end
        // collect one word MSB-first after the next capture
        while (!(m_c == 0 && m_cnt == 0)) tick(1'b1);
        got = 8'h00;
        for (int b = 0; b < 8; b++) begin
            got = {got[6:0], data_o};
            for (int k = 0; k < 15; k++) begin
                if (k == 7) word_in = 8'hFF;
                tick(1'b1);
            end
        end
        n_chk++;
        if (got !== 8'h3C) begin
            n_bad++;
            $display("FAIL R7 word actual=%h expected=3c", got);
        end
        chips += 0;
    endtask

    task automatic t_hold();
        logic sp, sd, sm, ss;
        for (int i = 0; i < 5; i++) tick(1'b1);
        sp = pn_o; sd = data_o; sm = period_o; ss = spread_o;
        for (int i = 0; i < 10; i++) begin
            word_in = 8'(i * 37);
            tick(1'b0);
        end
        chk("R9 pn_o held", pn_o, sp);
        chk("R9 data_o held", data_o, sd);
        chk("R9 period_o held", period_o, sm);
        chk("R9 spread_o held", spread_o, ss);
        for (int i = 0; i < 60; i++) begin
            tick(i % 3 == 0);
            check_all("R9 sparse strobe");
        end
    endtask

    task automatic t_midreset();
        for (int i = 0; i < 47; i++) tick(1'b1);
        rst = 1'b1;
        tick(1'b1);
        rst = 1'b0;
        chk("R10 pn_o", pn_o, 1'b0);
        chk("R10 period_o", period_o, 1'b1);
        chk("R10 data_o", data_o, 1'b0);
        word_in = 8'h81;
        for (int i = 0; i < 40; i++) begin
            tick(1'b1);
            check_all("R10 restart");
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(4 * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        rst = 1'b1; chip_en = 1'b0; word_in = 8'h00;
        model_reset();
        t_reset();
        t_pn_seq();
        t_balance();
        t_word();
        t_hold();
        t_midreset();
        finish_run();
    end
endmodule